// File: doc/BRIEF.md
# Paged EPROM Extended Read Sequencer

This block is the read-side command engine of a one-time-programmable byte memory. It sits behind a serial link whose bit-slot layer has been reduced to three things: byte-write strobes from the master, byte-read requests from the master, and a bus-reset input. The master writes an opening command byte and a two-byte start address. It then pulls bytes one request at a time. The engine walks the memory page by page. For every page it returns that page's redirection byte and a 16-bit check over it, then the page data from the current address up to the page's last byte, then a 16-bit check over that data. Once the top page has been sent, every further read returns all-ones.

The data array (2048 bytes, 64 pages of 32 bytes), the 64-entry redirection store and the CRC register are all inside the block. A programming port fills both stores with one-time-programmable semantics: an unwritten cell reads as all-ones, and a write can only clear bits. The programming voltage, the pulse timing and the analog layer are out of scope.

Top module: `ext_read_seq`

## Requirements
- R1: After rst_n low or a bus reset, the engine waits for a command byte. A read request is answered exactly one cycle later with rd_valid high for one cycle, and before a valid command and address have been taken the answer is 0xFF.
- R2: The read command code is 0xA5. If the first byte written is any other value, every later read returns 0xFF and further written bytes are ignored until a bus reset.
- R3: The start address arrives low byte first, then high byte. Only bits 10:0 are used, so 0xFFC3 addresses 0x7C3.
- R4: Each page begins with its redirection byte, followed by a 16-bit check. On the first page of a transaction that check covers the command byte, the low address byte, the high address byte (as sent) and the redirection byte, fed in that order into a zero-cleared CRC.
- R5: CRC polynomial x^16+x^15+x^2+1. Each byte is fed LSB first and the register starts at zero. The value is sent bitwise inverted, low byte first.
- R6: After the redirection check, data bytes are returned from the current address up to and including the last byte of that 32-byte page.
- R7: After the last data byte of a page, a 16-bit check is sent. It covers only the data bytes returned for that page and starts from a cleared register.
- R8: Each later page starts at its byte 0 with its redirection byte. Its check is computed from a cleared register over the redirection byte alone.
- R9: After the data check of page 63, every read returns 0xFF until a bus reset.
- R10: bus_reset aborts the sequence at any point. The next transaction is served as if it were the first.
- R11: A programming write with prog_sel=0 targets data byte prog_addr, and with prog_sel=1 it targets the redirection entry of page prog_addr[10:5]. The stored byte becomes the old value AND prog_data, and unwritten cells read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Link-level reset pulse; aborts any transaction |
| wr_valid | input | 1 | Master writes a byte this cycle |
| wr_byte | input | 8 | Byte written by the master |
| rd_req | input | 1 | Master requests one byte |
| rd_valid | output | 1 | Answer to the request of the previous cycle |
| rd_byte | output | 8 | Byte returned to the master |
| prog_we | input | 1 | Programming write strobe |
| prog_sel | input | 1 | 0: data array, 1: redirection store |
| prog_addr | input | 11 | Programming byte address |
| prog_data | input | 8 | Programming data (AND-merged) |

## Verification
The assertions assume that wr_valid and rd_req are never high in the same cycle. They also assume that neither is raised while bus_reset is high, and that programming writes happen only while no transaction is in progress. The bench drives every handshake through tasks that raise a single strobe for one cycle, issues bus resets as isolated one-cycle pulses, and performs all programming before it opens a transaction. Under these conditions the abort, end-of-page and end-of-memory properties see only the well-formed orderings that a real link layer produces.

// File: rtl/ers_pkg.sv
// Shared types and the CRC step used by the extended-read sequencer.
// Assumes CRC-16 with polynomial x^16+x^15+x^2+1 in reflected form, fed LSB first.
package ers_pkg;

    typedef enum logic [3:0] {
        S_CMD, S_ADR_LO, S_ADR_HI, S_RDIR, S_RCRC_LO, S_RCRC_HI,
        S_DATA, S_DCRC_LO, S_DCRC_HI, S_ONES
    } ers_state_e;

    // Advance a CRC-16 register by one byte, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] c;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ 16'hA001;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/ers_otp_store.sv
// One-time-programmable byte store. Cells power up as all-ones and a write
// can only clear bits (AND merge). Asynchronous read port.
// Assumes a single write port; contents are not touched by reset.
module ers_otp_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // Unprogrammed state of the array.
    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
    end

    // Merge a programming byte into the addressed cell.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= cells[waddr] & wdata;
    end

    // Read path.
    assign rdata = cells[raddr];

    // R11: a write never turns a 0 bit back into a 1.
    a_r11_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((cells[$past(waddr)] & ~$past(cells[waddr])) == 8'h00));

endmodule

// File: rtl/ers_crc_reg.sv
// CRC-16 accumulator with clear and byte update; an update may start from
// zero instead of the held value. Clear wins over update.
module ers_crc_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic        from_zero,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import ers_pkg::*;

    // Hold, clear or advance the check value.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= 16'h0000;
        else if (clr) crc <= 16'h0000;
        else if (upd) crc <= crc16_step(from_zero ? 16'h0000 : crc, din);
    end

    // R7: a clear leaves a zero register for the next page's data.
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 16'h0000));

endmodule

// File: rtl/ext_read_seq.sv
// Extended-read command engine: takes a command byte and a two-byte start
// address, then serves per page the redirection byte, its check, the page
// data to the page end and a data check, then all-ones after the last page.
// Assumes wr_valid and rd_req are never high together, and that programming
// happens only while no transaction is open.
module ext_read_seq #(
    parameter int         ADDR_W   = 11,
    parameter int         PAGE_W   = 5,
    parameter logic [7:0] READ_CMD = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    input  logic              prog_we,
    input  logic              prog_sel,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data
);
    import ers_pkg::*;

    localparam int PG_IDX_W = ADDR_W - PAGE_W;
    localparam int HI_W     = ADDR_W - 8;

    ers_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic              first_pg;
    logic [7:0]        data_q, redir_q, out_byte;
    logic [15:0]       crc;
    logic              crc_clr, crc_upd, crc_zero;
    logic [7:0]        crc_din;
    logic              page_last_byte;

    ers_otp_store #(.AW(ADDR_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .we(prog_we && !prog_sel), .waddr(prog_addr), .wdata(prog_data),
        .raddr(addr), .rdata(data_q)
    );

    ers_otp_store #(.AW(PG_IDX_W)) u_redir (
        .clk(clk), .rst_n(rst_n),
        .we(prog_we && prog_sel), .waddr(prog_addr[ADDR_W-1:PAGE_W]), .wdata(prog_data),
        .raddr(addr[ADDR_W-1:PAGE_W]), .rdata(redir_q)
    );

    ers_crc_reg u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .from_zero(crc_zero), .din(crc_din), .crc(crc)
    );

    assign page_last_byte = (addr[PAGE_W-1:0] == {PAGE_W{1'b1}});

    // Byte the current state would return to a read request.
    always_comb begin
        case (state)
            S_RDIR:                out_byte = redir_q;
            S_RCRC_LO, S_DCRC_LO:  out_byte = ~crc[7:0];
            S_RCRC_HI, S_DCRC_HI:  out_byte = ~crc[15:8];
            S_DATA:                out_byte = data_q;
            default:               out_byte = 8'hFF;
        endcase
    end

    // CRC controls: which byte enters the check in this cycle, and from which seed.
    always_comb begin
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        crc_zero = 1'b0;
        crc_din  = 8'h00;
        if (!bus_reset) begin
            case (state)
                S_CMD: if (wr_valid && wr_byte == READ_CMD) begin
                    crc_upd = 1'b1; crc_zero = 1'b1; crc_din = wr_byte;
                end
                S_ADR_LO, S_ADR_HI: if (wr_valid) begin
                    crc_upd = 1'b1; crc_din = wr_byte;
                end
                S_RDIR: if (rd_req) begin
                    crc_upd = 1'b1; crc_zero = !first_pg; crc_din = redir_q;
                end
                S_RCRC_HI: if (rd_req) crc_clr = 1'b1;
                S_DATA: if (rd_req) begin
                    crc_upd = 1'b1; crc_din = data_q;
                end
                default: ;
            endcase
        end
    end

    // Read answer register: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_byte  <= 8'hFF;
        end else begin
            rd_valid <= rd_req;
            rd_byte  <= rd_req ? out_byte : 8'hFF;
        end
    end

    // Transaction sequencer: command, address, then the page walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_CMD;
            addr     <= '0;
            first_pg <= 1'b0;
        end else if (bus_reset) begin
            state    <= S_CMD;
            first_pg <= 1'b0;
        end else begin
            case (state)
                S_CMD: if (wr_valid) state <= (wr_byte == READ_CMD) ? S_ADR_LO : S_ONES;
                S_ADR_LO: if (wr_valid) begin
                    addr[7:0] <= wr_byte;
                    state     <= S_ADR_HI;
                end
                S_ADR_HI: if (wr_valid) begin
                    addr[ADDR_W-1:8] <= wr_byte[HI_W-1:0];
                    first_pg         <= 1'b1;
                    state            <= S_RDIR;
                end
                S_RDIR:    if (rd_req) state <= S_RCRC_LO;
                S_RCRC_LO: if (rd_req) state <= S_RCRC_HI;
                S_RCRC_HI: if (rd_req) state <= S_DATA;
                S_DATA: if (rd_req) begin
                    addr <= addr + 1'b1;
                    if (page_last_byte) state <= S_DCRC_LO;
                end
                S_DCRC_LO: if (rd_req) state <= S_DCRC_HI;
                S_DCRC_HI: if (rd_req) begin
                    first_pg <= 1'b0;
                    state    <= (addr == '0) ? S_ONES : S_RDIR;
                end
                default: ;
            endcase
        end
    end

    // R1: an answer only ever follows a request.
    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R10: a bus reset always lands in the command-wait state.
    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == S_CMD));

    // R6: the last byte of a page hands over to the data check.
    a_r6_page_end_to_crc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && rd_req && !bus_reset && page_last_byte) |=> (state == S_DCRC_LO));

    // R9: once past the end, answers are all-ones.
    a_r9_ones_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ONES && rd_req) |=> (rd_byte == 8'hFF));

    // R8: a new page always starts at its byte 0.
    a_r8_page_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DCRC_HI && rd_req && !bus_reset && addr != '0) |=>
            (state == S_RDIR && addr[PAGE_W-1:0] == '0));

endmodule

// File: tb/ext_read_seq_test.sv
// Bench: behavioural model of the stores and the byte stream (queues),
// compared against every answer of the design.
module ext_read_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        prog_we = 1'b0;
    logic        prog_sel = 1'b0;
    logic [10:0] prog_addr = '0;
    logic [7:0]  prog_data = 8'hFF;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    byte unsigned m_data [2048];
    byte unsigned m_redir [64];
    byte unsigned exp_q [$];
    string        tag_q [$];

    always #10 clk = ~clk;

    ext_read_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .prog_we(prog_we), .prog_sel(prog_sel), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    function automatic int unsigned crc_b(int unsigned c, int unsigned d);
        int unsigned r = c;
        for (int i = 0; i < 8; i++) begin
            if (((r ^ (d >> i)) & 1) != 0) r = (r >> 1) ^ 32'hA001;
            else                           r = r >> 1;
        end
        return r & 32'hFFFF;
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(bit sel, int unsigned a, byte unsigned d);
        @(negedge clk);
        prog_we = 1'b1; prog_sel = sel; prog_addr = a[10:0]; prog_data = d;
        if (sel) m_redir[a[10:5]] = m_redir[a[10:5]] & d;
        else     m_data[a[10:0]]  = m_data[a[10:0]] & d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic wr(byte unsigned b);
        @(negedge clk);
        wr_valid = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // One read: answer sampled at the following falling edge.
    task automatic rd();
        byte unsigned e;
        string t;
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
        end else begin
            e = 8'hFF; t = "R9";
        end
        check({t, " valid"}, rd_valid, 1);
        check(t, rd_byte, e);
        @(negedge clk);
        check("R1 valid drops", rd_valid, 0);
    endtask

    task automatic breset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic push(byte unsigned b, string t);
        exp_q.push_back(b); tag_q.push_back(t);
    endtask

    // Expected stream of a read transaction from the given address bytes.
    task automatic open_txn(byte unsigned lo, byte unsigned hi);
        int unsigned c, a;
        bit first = 1'b1;
        wr(8'hA5); wr(lo); wr(hi);
        a = ((hi * 256) + lo) & 32'h7FF;
        c = crc_b(crc_b(crc_b(0, 8'hA5), lo), hi);
        forever begin
            push(m_redir[a / 32], first ? "R4 redir" : "R8 redir");
            c = first ? crc_b(c, m_redir[a / 32]) : crc_b(0, m_redir[a / 32]);
            push(~c & 8'hFF, first ? "R4/R5 crc lo" : "R8 crc lo");
            push((~c >> 8) & 8'hFF, first ? "R4/R5 crc hi" : "R8 crc hi");
            c = 0;
            do begin
                push(m_data[a], "R6 data");
                c = crc_b(c, m_data[a]);
                a++;
            end while (a % 32 != 0);
            push(~c & 8'hFF, "R7 crc lo");
            push((~c >> 8) & 8'hFF, "R7 crc hi");
            if (a == 2048) break;
            first = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) m_data[i] = 8'hFF;
        for (int i = 0; i < 64; i++)   m_redir[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and an idle read.
        check("R1 reset valid", rd_valid, 0);
        check("R1 reset byte", rd_byte, 8'hFF);
        rd();

        // R11: programme pages 0, 1, 62, 63 and their redirection entries.
        for (int i = 0; i < 64; i++) prog(1'b0, i, 8'((i * 37 + 11) ^ 8'h5C));
        for (int i = 1984; i < 2048; i++) prog(1'b0, i, 8'((i * 13 + 7) ^ 8'hA3));
        for (int p = 0; p < 64; p += 1) if (p < 2 || p > 61) prog(1'b1, p * 32, 8'(p * 3 + 1));
        prog(1'b0, 12'h7E6, 8'h0F);   // R11: second write to same cell ANDs

        // R4 R5 R6 R7 R9: last page from offset 5, then trailing ones.
        open_txn(8'hE5, 8'h07);
        for (int i = 0; i < 35; i++) rd();
        breset();

        // R3 R8: high address bits ignored, walk two pages to the end.
        open_txn(8'hC3, 8'hFF);
        for (int i = 0; i < 73; i++) rd();
        breset();

        // R10: abort mid-page, then a fresh transaction behaves as first.
        open_txn(8'h00, 8'h00);
        for (int i = 0; i < 10; i++) rd();
        breset();
        open_txn(8'h1E, 8'h00);
        for (int i = 0; i < 12; i++) rd();
        breset();

        // R2: wrong command gives all-ones, address bytes ignored.
        wr(8'h3C); wr(8'h00); wr(8'h00);
        for (int i = 0; i < 4; i++) begin
            push(8'hFF, "R2 bad cmd");
        end
        for (int i = 0; i < 4; i++) rd();
        breset();

        // R11: verify merged cell through a normal read.
        open_txn(8'hE6, 8'h07);
        for (int i = 0; i < 4; i++) rd();
        breset();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule